// File: doc/BRIEF.md
# PCI Power-State Access Gate

This block sits between a host bus target and the register and interrupt logic of a storage controller, and it enforces the rules of the PCI D0 and D3 power states. It keeps a 2-bit power-state field in configuration space. Each request carries a tag for configuration, memory or I/O space. In the cycle the request is presented, the gate forwards it to the controller or ends it with a master abort. In low power, only configuration traffic is accepted.

The gate also owns the outputs that low power affects. While in D3 the interrupt line is held low, whatever the status and enable bits say. The port interface is reported as idle, as if no device were attached. A wake request is raised only outside legacy mode. Leaving D3 does not reset anything. An interrupt that stayed pending through low power appears as soon as the field returns to D0.

Top module: `pm_access_gate`

## Requirements
- R1: After reset the power-state field reads 00 (D0), port_active_o is high, and pme_o is low.
- R2: A configuration-space access (req_space_i = 00) is always forwarded (fwd_o high, abort_o low), in every power state.
- R3: While the field holds 11 (D3), a memory access (req_space_i = 01) or an I/O access (req_space_i = 10) is not forwarded and ends with abort_o high in the same cycle.
- R4: While the field holds 00, 01 or 10, memory and I/O accesses are forwarded and never aborted.
- R5: A configuration write to address PM_ADDR loads req_wdata_i[1:0] into the field. The new value governs gating from the next cycle on, and the writing access itself is forwarded.
- R6: While in D3, irq_o stays low even when a status bit and its matching enable bit are both set.
- R7: When the field returns from 11 to 00, an interrupt still pending and enabled drives irq_o high in the next cycle. No reset takes place, so the field and the pending status are kept.
- R8: With legacy_mode_i high, pme_o is never asserted, whatever wake events arrive and whatever the power state.
- R9: Outside legacy mode, pme_o is high exactly while wake_event_i is high and the field holds 11.
- R10: port_active_o is low while the field holds 11 and high otherwise.
- R11: A configuration read at PM_ADDR returns the field in rd_data_o[1:0] with all upper bits zero. Any other access returns zero on rd_data_o.
- R12: A configuration write to any address other than PM_ADDR, and any read, leaves the field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present this cycle |
| req_space_i | input | 2 | Space tag: 00 config, 01 memory, 10 I/O |
| req_write_i | input | 1 | Access is a write |
| req_addr_i | input | ADDR_W | Access offset within the space |
| req_wdata_i | input | DATA_W | Write data |
| fwd_o | output | 1 | Pass the access to the controller |
| abort_o | output | 1 | End the access with master abort |
| rd_data_o | output | DATA_W | Power-state field readback |
| irq_status_i | input | N_IRQ | Interrupt status bits |
| irq_enable_i | input | N_IRQ | Interrupt enable bits |
| legacy_mode_i | input | 1 | Controller is in legacy operating mode |
| wake_event_i | input | 1 | Attach or interlock-switch event |
| irq_o | output | 1 | Gated interrupt line |
| pme_o | output | 1 | Power-management event request |
| port_active_o | output | 1 | Port interface driven as attached |

## Verification
The bench writes the field and issues a memory access in the very next cycle. A design that applied the write a cycle late would forward that access instead of aborting it. The two reserved state codes, 01 and 10, are walked with memory and I/O traffic. A gate that decoded "not D0" instead of "equals D3" would abort those accesses. An interrupt is left pending through a D3 round trip. The bench checks that irq_o stays low during the write back to D0 and goes high in the cycle after it. A design that cleared state on exit would lose the interrupt or the field value. A design that gated on the wrong cycle would show the interrupt too early. The bench also drives wake events in D3 with legacy mode on and off, which catches a wake request that ignores the legacy flag.

// File: rtl/pm_gate_pkg.sv
`timescale 1ns/1ps
package pm_gate_pkg;
  localparam int unsigned PS_W = 2;

  typedef enum logic [1:0] {
    SPC_CFG = 2'b00,
    SPC_MEM = 2'b01,
    SPC_IO  = 2'b10,
    SPC_RSV = 2'b11
  } space_e;

  typedef enum logic [PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pm_state_reg.sv
`timescale 1ns/1ps
module pm_state_reg
  import pm_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] PM_ADDR = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  space_e            req_space_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PS_W-1:0]   wr_field_i,
  output pstate_e           pstate_o,
  output logic              low_power_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - PS_W;

  pstate_e state_q;
  logic    field_hit;

  assign field_hit = req_valid_i && (req_space_i == SPC_CFG) && (req_addr_i == PM_ADDR);

  // no reset on leaving D3: only rst_ni clears the field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_D0;
    end else if (field_hit && req_write_i) begin
      state_q <= pstate_e'(wr_field_i);
    end
  end

  assign pstate_o    = state_q;
  // reserved codes gate like D0
  assign low_power_o = (state_q == PS_D3);
  assign rd_data_o   = (field_hit && !req_write_i) ? {{PAD_W{1'b0}}, state_q} : '0;
endmodule

// File: rtl/pm_access_filter.sv
`timescale 1ns/1ps
module pm_access_filter
  import pm_gate_pkg::*;
(
  input  logic   req_valid_i,
  input  space_e req_space_i,
  input  logic   low_power_i,
  output logic   fwd_o,
  output logic   abort_o
);
  logic is_cfg;

  assign is_cfg  = (req_space_i == SPC_CFG);
  assign fwd_o   = req_valid_i && (is_cfg || !low_power_i);
  assign abort_o = req_valid_i && !is_cfg && low_power_i;
endmodule

// File: rtl/pm_event_gate.sv
`timescale 1ns/1ps
module pm_event_gate #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_status_i,
  input  logic [N_IRQ-1:0] irq_enable_i,
  input  logic             low_power_i,
  input  logic             legacy_mode_i,
  input  logic             wake_event_i,
  output logic             irq_o,
  output logic             pme_o,
  output logic             port_active_o
);
  logic [N_IRQ-1:0] live;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign live[g] = irq_status_i[g] & irq_enable_i[g];
  end

  // status stays outside this block, so a pending bit reappears on D0
  assign irq_o         = (|live) && !low_power_i;
  assign pme_o         = wake_event_i && low_power_i && !legacy_mode_i;
  assign port_active_o = !low_power_i;
endmodule

// File: rtl/pm_access_gate.sv
`timescale 1ns/1ps
module pm_access_gate
  import pm_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_IRQ  = 4,
  parameter logic [ADDR_W-1:0] PM_ADDR = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_space_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              fwd_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_IRQ-1:0]  irq_status_i,
  input  logic [N_IRQ-1:0]  irq_enable_i,
  input  logic              legacy_mode_i,
  input  logic              wake_event_i,
  output logic              irq_o,
  output logic              pme_o,
  output logic              port_active_o
);
  space_e  space;
  pstate_e pstate;
  logic    low_power;
  logic    unused_wdata;

  assign space        = space_e'(req_space_i);
  assign unused_wdata = ^req_wdata_i[DATA_W-1:PS_W];

  pm_state_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PM_ADDR(PM_ADDR)
  ) state_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_space_i(space),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .wr_field_i (req_wdata_i[PS_W-1:0]),
    .pstate_o   (pstate),
    .low_power_o(low_power),
    .rd_data_o  (rd_data_o)
  );

  pm_access_filter filter_i (
    .req_valid_i(req_valid_i),
    .req_space_i(space),
    .low_power_i(low_power),
    .fwd_o      (fwd_o),
    .abort_o    (abort_o)
  );

  pm_event_gate #(
    .N_IRQ(N_IRQ)
  ) event_i (
    .irq_status_i (irq_status_i),
    .irq_enable_i (irq_enable_i),
    .low_power_i  (low_power),
    .legacy_mode_i(legacy_mode_i),
    .wake_event_i (wake_event_i),
    .irq_o        (irq_o),
    .pme_o        (pme_o),
    .port_active_o(port_active_o)
  );
endmodule

// File: rtl/pm_access_gate_chk.sv
`timescale 1ns/1ps
module pm_access_gate_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] PM_ADDR = 8'h44
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_space_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              fwd_o,
  input logic              abort_o,
  input logic              legacy_mode_i,
  input logic              irq_o,
  input logic              pme_o,
  input logic              port_active_o,
  input logic [1:0]        pstate_i
);
  logic wr_hit;
  assign wr_hit = req_valid_i && req_write_i && (req_space_i == 2'b00) && (req_addr_i == PM_ADDR);

  // R2
  cfg_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_space_i == 2'b00) |-> (fwd_o && !abort_o));

  // R3
  d3_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_space_i != 2'b00 && pstate_i == 2'b11) |-> (abort_o && !fwd_o));

  // R4
  d0_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_space_i != 2'b00 && pstate_i != 2'b11) |-> (fwd_o && !abort_o));

  // R5
  pstate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (pstate_i == $past(req_wdata_i[1:0])));

  // R12
  pstate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> (pstate_i == $past(pstate_i)));

  // R6
  d3_irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == 2'b11) |-> !irq_o);

  // R8
  legacy_pme_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_mode_i |-> !pme_o);

  // R10
  port_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == 2'b11) |-> !port_active_o);
endmodule

bind pm_access_gate pm_access_gate_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PM_ADDR(PM_ADDR)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_space_i  (req_space_i),
  .req_write_i  (req_write_i),
  .req_addr_i   (req_addr_i),
  .req_wdata_i  (req_wdata_i),
  .fwd_o        (fwd_o),
  .abort_o      (abort_o),
  .legacy_mode_i(legacy_mode_i),
  .irq_o        (irq_o),
  .pme_o        (pme_o),
  .port_active_o(port_active_o),
  .pstate_i     (pstate)
);

// File: tb/pm_access_gate_tb_top.sv
`timescale 1ns/1ps
module pm_access_gate_tb_top;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_IRQ  = 4;
  localparam logic [ADDR_W-1:0] PM_ADDR = 8'h44;
  localparam logic [ADDR_W-1:0] OTHER_ADDR = 8'h10;
  localparam logic [1:0] CFG = 2'b00, MEM = 2'b01, IO = 2'b10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_space = 2'b00;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              fwd, abort_s;
  logic [DATA_W-1:0] rd_data;
  logic [N_IRQ-1:0]  irq_status = '0;
  logic [N_IRQ-1:0]  irq_enable = '0;
  logic              legacy = 1'b0;
  logic              wake = 1'b0;
  logic              irq, pme, port_active;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_access_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IRQ(N_IRQ), .PM_ADDR(PM_ADDR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_space_i(req_space), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .fwd_o(fwd), .abort_o(abort_s), .rd_data_o(rd_data),
    .irq_status_i(irq_status), .irq_enable_i(irq_enable),
    .legacy_mode_i(legacy), .wake_event_i(wake),
    .irq_o(irq), .pme_o(pme), .port_active_o(port_active)
  );

  typedef struct packed {
    logic [1:0] sp;
    logic       wr;
    logic       pm;
    logic [1:0] wd;
    logic       fwd;
    logic       ab;
    logic [1:0] st;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{MEM, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00},
    '{IO,  1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00},
    '{CFG, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 2'b11},
    '{MEM, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 2'b11},
    '{IO,  1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b11},
    '{CFG, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b11},
    '{CFG, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 2'b11},
    '{MEM, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 2'b11},
    '{CFG, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 2'b01},
    '{MEM, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b01},
    '{CFG, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 2'b10},
    '{IO,  1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b10},
    '{CFG, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 2'b11},
    '{CFG, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 2'b00},
    '{MEM, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, settle 1 ns, caller samples before the next posedge
  task automatic drive(input logic [1:0] sp, input logic wr, input logic [ADDR_W-1:0] ad,
                       input logic [1:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_space = sp;
    req_write = wr;
    req_addr  = ad;
    req_wdata = {30'h2aaa_5555, wd};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    #1;
  endtask

  task automatic read_state(input string req, input logic [1:0] exp);
    drive(CFG, 1'b0, PM_ADDR, 2'b00);
    check(req, rd_data, {30'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 port_active", {31'd0, port_active}, 32'd1);
    check("R1 pme", {31'd0, pme}, 32'd0);
    read_state("R1 state", 2'b00);
    // R11 readback is zero for a non-field access
    drive(CFG, 1'b0, OTHER_ADDR, 2'b00);
    check("R11 other addr", rd_data, 32'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      drive(VECS[i].sp, VECS[i].wr, VECS[i].pm ? PM_ADDR : OTHER_ADDR, VECS[i].wd);
      if (VECS[i].sp == CFG) tag = "R2";
      else if (VECS[i].ab) tag = "R3";
      else tag = "R4";
      check({tag, " fwd"}, {31'd0, fwd}, {31'd0, VECS[i].fwd});
      check({tag, " abort"}, {31'd0, abort_s}, {31'd0, VECS[i].ab});
      if (VECS[i].sp == CFG && VECS[i].wr && VECS[i].pm) tag = "R5 state";
      else tag = "R12 state";
      read_state(tag, VECS[i].st);
    end

    // R5 write takes effect in the very next cycle
    drive(CFG, 1'b1, PM_ADDR, 2'b11);
    check("R5 writer fwd", {31'd0, fwd}, 32'd1);
    drive(MEM, 1'b0, OTHER_ADDR, 2'b00);
    check("R5 next-cycle abort", {31'd0, abort_s}, 32'd1);
    drive(CFG, 1'b1, PM_ADDR, 2'b00);
    drive(IO, 1'b0, OTHER_ADDR, 2'b00);
    check("R5 next-cycle fwd", {31'd0, fwd}, 32'd1);
    idle();

    // R6 / R7 interrupt gating and deferred delivery
    irq_status = 4'b0010;
    irq_enable = 4'b0010;
    #1;
    check("R6 D0 irq live", {31'd0, irq}, 32'd1);
    irq_enable = 4'b0001;
    #1;
    check("R6 disabled irq", {31'd0, irq}, 32'd0);
    irq_enable = 4'b0011;
    drive(CFG, 1'b1, PM_ADDR, 2'b11);
    check("R6 irq during write", {31'd0, irq}, 32'd1);
    idle();
    check("R6 D3 irq masked", {31'd0, irq}, 32'd0);
    check("R10 D3 port idle", {31'd0, port_active}, 32'd0);
    // R9 / R8 wake request
    wake = 1'b1;
    #1;
    check("R9 pme in D3", {31'd0, pme}, 32'd1);
    legacy = 1'b1;
    #1;
    check("R8 legacy pme", {31'd0, pme}, 32'd0);
    legacy = 1'b0;
    wake = 1'b0;
    #1;
    check("R9 pme no wake", {31'd0, pme}, 32'd0);
    drive(CFG, 1'b1, PM_ADDR, 2'b00);
    check("R7 irq held during exit write", {31'd0, irq}, 32'd0);
    idle();
    check("R7 deferred irq", {31'd0, irq}, 32'd1);
    check("R10 D0 port active", {31'd0, port_active}, 32'd1);
    wake = 1'b1;
    #1;
    check("R9 pme in D0", {31'd0, pme}, 32'd0);
    wake = 1'b0;
    read_state("R7 state kept", 2'b00);

    // R7 round trip keeps a reserved code and pending status
    drive(CFG, 1'b1, PM_ADDR, 2'b10);
    drive(CFG, 1'b1, PM_ADDR, 2'b11);
    drive(MEM, 1'b0, OTHER_ADDR, 2'b00);
    check("R3 round trip abort", {31'd0, abort_s}, 32'd1);
    drive(CFG, 1'b1, PM_ADDR, 2'b01);
    read_state("R7 round trip state", 2'b01);
    check("R7 round trip irq", {31'd0, irq}, 32'd1);
    idle();

    // R8 legacy in D3 with wake held for several cycles
    legacy = 1'b1;
    wake = 1'b1;
    drive(CFG, 1'b1, PM_ADDR, 2'b11);
    idle();
    check("R8 legacy D3 pme", {31'd0, pme}, 32'd0);
    idle();
    check("R8 legacy D3 pme later", {31'd0, pme}, 32'd0);
    legacy = 1'b0;
    wake = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule